// File: doc/BRIEF.md
# Encoder Velocity Capture Timer

This block measures how fast an encoder turns. A decoder upstream hands it a single-cycle strobe for each encoder clock pulse. A down-counting window timer runs beside a pulse counter. When the timer reaches zero, four things happen in the same cycle. The pulse total of the window just ended is latched as the captured velocity. The pulse counter restarts. The timer reloads from the reload input. On the following cycle the block raises a window-end event. If the captured total is below the compare input, it also raises a low-speed event.

The running timer, the running pulse count and the last captured total are all visible on output ports. A clear command stops the current measurement: it zeroes the timer and the pulse counter without disturbing the last capture. The block has no data stream, so it has no valid/ready handshake. Pulses and the clear command are plain level-per-cycle inputs. Both events are one-cycle strobes with no back-pressure, and any consumer that needs them must catch them in the cycle they appear.

Top module: `enc_vel_meter`

## Requirements
- R1: While reset is held and in the first cycle after it, `timer_out`, `count_out` and `capture_out` read zero and both events are low.
- R2: When `timer_out` is nonzero and `vel_clear` is low, `timer_out` falls by exactly one on the next clock.
- R3: A cycle in which `timer_out` is zero and `vel_clear` is low is an expiry cycle, and `timer_out` shows `reload_val` on the next clock. A window therefore lasts `reload_val` + 1 clocks. Because the timer resets to zero, the first expiry is the first cycle after reset.
- R4: `ovf_evt` is high for exactly the one cycle that follows each expiry cycle, and is low at every other time.
- R5: On the cycle after an expiry, `capture_out` shows the number of `enc_pulse` cycles counted in the window that just ended. At all other times it holds its value.
- R6: `count_out` rises by one on the clock after each cycle with `enc_pulse` high. After an expiry cycle it restarts at 1 if `enc_pulse` was high in that expiry cycle, and at 0 if it was not. A pulse in an expiry cycle therefore belongs to the new window.
- R7: `slow_evt` is high together with `ovf_evt` exactly when the new `capture_out` is smaller than the value `cmp_val` had in the expiry cycle, compared as unsigned numbers. `slow_evt` is never high without `ovf_evt`.
- R8: A cycle with `vel_clear` high forces `timer_out` and `count_out` to zero on the next clock. That cycle never counts as an expiry, even when the timer is zero. It raises no event and leaves `capture_out` unchanged.
- R9: With `reload_val` equal to zero and no clear, every cycle is an expiry, so `ovf_evt` stays high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_pulse | input | 1 | One encoder clock pulse per high cycle |
| vel_clear | input | 1 | Clear timer and pulse counter |
| reload_val | input | 32 | Window timer reload value |
| cmp_val | input | 32 | Low-speed threshold |
| timer_out | output | 32 | Current window timer value |
| count_out | output | 32 | Running pulse count of the current window |
| capture_out | output | 32 | Pulse total of the last completed window |
| ovf_evt | output | 1 | Window-end strobe |
| slow_evt | output | 1 | Low-speed strobe, high only with `ovf_evt` |

## Verification
Every output is registered and depends on the inputs of the previous clock only. The timer, the pulse count, the capture and both strobes are all due exactly one clock after the cycle whose inputs caused them. The bench drives inputs on the falling edge. A behavioural model consumes those inputs on the rising edge, and the outputs are compared with the model on the next falling edge, so each result is checked in the cycle it first becomes due. Directed checks on the reset state, on a clear issued in an expiry cycle and on a zero reload read the outputs at that same one-clock offset.

// File: rtl/vel_pkg.sv
package vel_pkg;
  localparam int unsigned VEL_W = 32;

  typedef struct packed {
    logic ovf;
    logic slow;
  } vel_evt_t;
endpackage

// File: rtl/vel_window_timer.sv
module vel_window_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] reload,
  output logic [W-1:0] tmr,
  output logic         expire
);
  // expiry is the zero cycle unless a clear overrides it
  assign expire = (tmr == '0) && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tmr <= '0;
    end else if (expire) begin
      tmr <= reload;
    end else begin
      tmr <= tmr - W'(1);
    end
  end
endmodule

// File: rtl/vel_pulse_counter.sv
module vel_pulse_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         expire,
  input  logic         pulse,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (expire) begin
      // the pulse of the expiry cycle opens the new window
      cnt <= W'(pulse);
    end else begin
      cnt <= cnt + W'(pulse);
    end
  end
endmodule

// File: rtl/vel_capture_cmp.sv
module vel_capture_cmp
  import vel_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expire,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thresh,
  output logic [W-1:0] cap,
  output vel_evt_t     evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap <= '0;
      evt <= '0;
    end else begin
      evt.ovf  <= expire;
      evt.slow <= expire && (cnt < thresh);
      if (expire) begin
        cap <= cnt;
      end
    end
  end
endmodule

// File: rtl/enc_vel_meter.sv
module enc_vel_meter
  import vel_pkg::*;
#(
  parameter int unsigned W = VEL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_pulse,
  input  logic         vel_clear,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] timer_out,
  output logic [W-1:0] count_out,
  output logic [W-1:0] capture_out,
  output logic         ovf_evt,
  output logic         slow_evt
);
  logic     expire;
  vel_evt_t evt;

  vel_window_timer #(.W(W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(vel_clear),
    .reload(reload_val), .tmr(timer_out), .expire(expire)
  );

  vel_pulse_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(vel_clear),
    .expire(expire), .pulse(enc_pulse), .cnt(count_out)
  );

  vel_capture_cmp #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .cnt(count_out), .thresh(cmp_val), .cap(capture_out), .evt(evt)
  );

  assign ovf_evt  = evt.ovf;
  assign slow_evt = evt.slow;
endmodule

// File: rtl/enc_vel_meter_chk.sv
module enc_vel_meter_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enc_pulse,
  input logic         vel_clear,
  input logic [W-1:0] reload_val,
  input logic [W-1:0] timer_out,
  input logic [W-1:0] count_out,
  input logic [W-1:0] capture_out,
  input logic         ovf_evt,
  input logic         slow_evt
);
  // R2
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vel_clear && timer_out != '0) |=> (timer_out == $past(timer_out) - W'(1)));

  // R3
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vel_clear && timer_out == '0) |=> (timer_out == $past(reload_val)));

  // R4
  ovf_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vel_clear && timer_out == '0) |=> ovf_evt);

  // R4
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vel_clear || timer_out != '0) |=> !ovf_evt);

  // R5
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_evt |-> $stable(capture_out));

  // R7
  slow_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_evt |-> ovf_evt);

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vel_clear |=> (timer_out == '0 && count_out == '0 && !ovf_evt));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vel_clear && timer_out != '0 && enc_pulse) |=> (count_out == $past(count_out) + W'(1)));
endmodule

bind enc_vel_meter enc_vel_meter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enc_pulse(enc_pulse), .vel_clear(vel_clear),
  .reload_val(reload_val), .timer_out(timer_out), .count_out(count_out),
  .capture_out(capture_out), .ovf_evt(ovf_evt), .slow_evt(slow_evt)
);

// File: tb/tb_enc_vel_meter.sv
module tb_enc_vel_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_pulse = 1'b0;
  logic        vel_clear = 1'b0;
  logic [31:0] reload_val = 32'd9;
  logic [31:0] cmp_val = 32'd4;
  logic [31:0] timer_out, count_out, capture_out;
  logic        ovf_evt, slow_evt;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural model state
  longint m_tmr = 0, m_cnt = 0, m_cap = 0;
  bit m_ovf = 0, m_slow = 0;

  always #10 clk = ~clk;

  enc_vel_meter dut (
    .clk(clk), .rst_n(rst_n), .enc_pulse(enc_pulse), .vel_clear(vel_clear),
    .reload_val(reload_val), .cmp_val(cmp_val), .timer_out(timer_out),
    .count_out(count_out), .capture_out(capture_out),
    .ovf_evt(ovf_evt), .slow_evt(slow_evt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_tmr = 0; m_cnt = 0; m_cap = 0; m_ovf = 0; m_slow = 0;
    end else if (vel_clear) begin
      m_tmr = 0; m_cnt = 0; m_ovf = 0; m_slow = 0;
    end else if (m_tmr == 0) begin
      m_cap  = m_cnt;
      m_slow = (m_cnt < longint'(cmp_val));
      m_ovf  = 1;
      m_cnt  = enc_pulse ? 1 : 0;
      m_tmr  = reload_val;
    end else begin
      m_tmr = m_tmr - 1;
      m_cnt = (m_cnt + (enc_pulse ? 1 : 0)) & 64'hFFFF_FFFF;
      m_ovf = 0;
      m_slow = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R2/R3 timer", timer_out, m_tmr);
      chk("R6 count", count_out, m_cnt);
      chk("R5 capture", capture_out, m_cap);
      chk("R4 ovf", ovf_evt, m_ovf);
      chk("R7 slow", slow_evt, m_slow);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enc_pulse = (period > 0) && ((i % period) == 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 timer", timer_out, 0);
    chk("R1 count", count_out, 0);
    chk("R1 capture", capture_out, 0);
    chk("R1 ovf", ovf_evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 capture after release", capture_out, 0);
    // R3 first expiry right after reset
    chk("R3 first expiry", ovf_evt, 1);

    run(60, 1);   // fast: 10 per window
    run(60, 3);   // slower, crosses threshold
    run(40, 0);   // stopped
    run(77, 2);
    cmp_val = 32'd100;
    run(50, 1);

    // R8 clear while timer at zero
    while (timer_out != 0) @(negedge clk);
    begin
      logic [31:0] cap_before;
      cap_before = capture_out;
      vel_clear = 1'b1; enc_pulse = 1'b1;
      @(negedge clk);
      vel_clear = 1'b0; enc_pulse = 1'b0;
      chk("R8 timer", timer_out, 0);
      chk("R8 count", count_out, 0);
      chk("R8 no event", ovf_evt, 0);
      chk("R8 capture kept", capture_out, cap_before);
    end
    // R8 clear mid-window
    run(5, 1);
    vel_clear = 1'b1;
    @(negedge clk);
    vel_clear = 1'b0;
    chk("R8 mid count", count_out, 0);

    // R9 zero reload
    reload_val = 32'd0;
    cmp_val = 32'd1;
    run(12, 2);
    @(negedge clk);
    chk("R9 ovf a", ovf_evt, 1);
    @(negedge clk);
    chk("R9 ovf b", ovf_evt, 1);

    reload_val = 32'd3;
    run(40, 1);
    run(40, 5);
    reload_val = 32'd20;
    cmp_val = 32'd7;
    run(200, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule